// File: doc/BRIEF.md
# Memory ordering group tracker

This block sits beside the dispatch stage of an out-of-order core and sorts memory operations into ordering groups. Each dispatched operation carries a load flag, a store flag and a barrier flag (the operation has side effects). The block either opens a new group for it or adds it to the youngest open load group, and returns the group ID in the same cycle. For every new group it records which older groups must finish first. Successors are held as a bit per group pair, and a pending-predecessor counter is kept per group. A one-bit ready flag per group tells the scheduler which groups may issue.

Execution is reported per operation through an issue port (the first operation of a group has started) and an execute port (one operation of a group has finished). When the last operation of a group finishes, the slot is released, its successors lose one pending predecessor, and any of the four youngest-group pointers (load, store, load barrier, store barrier) that name it are cleared. Load-queue and store-queue occupancy is counted from dispatch to retire, and a two-bit status says whether the operation on the dispatch port can be taken. A no-alias mode input drops the edges that exist only because addresses might overlap.

Top module: `mem_order_tracker`

## Requirements
- R1: After reset no group is ready, both occupancy counts are 0, every dispatch status is 0 and the first new group gets ID 1.
- R2: New groups take IDs 1, 2, ..., NUM_GROUPS-1 and then wrap to 1. ID 0 is never returned. If the slot of the next ID is still occupied, an operation that needs a new group gets status 3 and is not accepted.
- R3: Status codes are 0 available, 1 load queue full, 2 store queue full, 3 no free group slot. An operation with the load flag set sees code 1 when the load queue is full, before any store-queue test. Code 2 is given when the store flag is set and the store queue is full.
- R4: An accepted operation adds one to the load count if it loads and one to the store count if it stores. A retire with the matching flag subtracts one, and a retire on an empty count leaves it at 0.
- R5: Every accepted store (with or without the load flag) opens a new group. That group depends on the youngest load or load-barrier group, on the store-barrier group, and on the store group when it differs from the store-barrier group.
- R6: With no_alias high, a store drops its edges to the load dominator and to the store group, and a new load group drops its edge to the store group. The edges from the store-barrier group and all load-barrier edges remain.
- R7: A load joins the current load group, returning that group's ID, unless one of these holds: it is a barrier; there is no open load group; the youngest load group is the load-barrier group; a store group is younger than that load group; or that group has already seen an issue or execute event.
- R8: A load that opens a group depends on the store group (unless R6 applies). A barrier load also depends on the youngest load group. A plain load also depends on the load-barrier group.
- R9: A group's ready bit is 1 while it is occupied and every predecessor recorded at its creation has been released. Bit 0 is always 0.
- R10: A group is released in the cycle its executed count reaches its operation count. Its ready bit drops, pointers naming it are cleared, and later loads cannot join it.
- R11: A release and a dispatch in the same cycle: the dispatch decision and edges already see the released group gone, but slot availability is judged on the occupancy before the release.
- R12: Issue or execute events naming an unoccupied ID, and dispatches with neither load nor store set, change nothing: the accept is 0 and later IDs and ready bits are as if the event never happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| no_alias | input | 1 | Drop edges that exist only for possible address overlap |
| disp_valid | input | 1 | Dispatch request |
| disp_load | input | 1 | Operation reads memory |
| disp_store | input | 1 | Operation writes memory |
| disp_barrier | input | 1 | Operation has side effects |
| disp_status | output | 2 | 0 available, 1 load queue full, 2 store queue full, 3 no slot |
| disp_accept | output | 1 | Operation taken this cycle |
| disp_gid | output | $clog2(NUM_GROUPS) | Group ID of the accepted operation, else 0 |
| issue_valid | input | 1 | An operation of a group started executing |
| issue_gid | input | $clog2(NUM_GROUPS) | Group of the started operation |
| exec_valid | input | 1 | An operation of a group finished executing |
| exec_gid | input | $clog2(NUM_GROUPS) | Group of the finished operation |
| retire_valid | input | 1 | An operation retired |
| retire_load | input | 1 | Retired operation held a load-queue entry |
| retire_store | input | 1 | Retired operation held a store-queue entry |
| grp_ready | output | NUM_GROUPS | Ready bit per group ID |
| lq_used | output | $clog2(LQ_DEPTH+1) | Load-queue occupancy |
| sq_used | output | $clog2(SQ_DEPTH+1) | Store-queue occupancy |

## Verification
The hardest state to reach from the ports is a table with every group slot occupied. The store queue is smaller than the group table, so the stimulus dispatches each store together with a retire of a store. This holds the occupancy steady while slots run out, and a release is then issued in the same cycle as a dispatch to expose the ordering of R11. A behavioural model keeps groups as creation-ordered records with explicit predecessor sets and compares every output on every cycle. It runs through directed sequences and a long random phase that mixes barriers, no-alias mode, stray events and retires.

// File: rtl/mot_pkg.sv
package mot_pkg;

    typedef enum logic [1:0] {
        DS_AVAIL   = 2'd0,
        DS_LQ_FULL = 2'd1,
        DS_SQ_FULL = 2'd2,
        DS_NO_SLOT = 2'd3
    } disp_status_e;

    typedef struct packed {
        logic is_ld;
        logic is_st;
        logic is_bar;
    } mem_op_t;

    function automatic int unsigned width_for(input int unsigned max_value);
        return (max_value < 2) ? 1 : $clog2(max_value + 1);
    endfunction

endpackage

// File: rtl/mot_queue_count.sv
module mot_queue_count #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = mot_pkg::width_for(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [CW-1:0] cnt_q;
    logic          dec_ok;

    assign dec_ok = dec && (cnt_q != '0);
    assign count  = cnt_q;
    assign full   = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CW'(inc) - CW'(dec_ok);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec_ok) |-> !full);  // R4
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!inc && cnt_q == '0) |=> cnt_q == '0);  // R4

endmodule

// File: rtl/mot_group_table.sv
module mot_group_table #(
    parameter int unsigned NG  = 8,
    parameter int unsigned IW  = 6,
    localparam int unsigned IDW = $clog2(NG),
    localparam int unsigned PW  = mot_pkg::width_for(NG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           alloc_en,
    input  logic [IDW-1:0] alloc_id,
    input  logic [NG-1:0]  alloc_pred,
    input  logic           join_en,
    input  logic [IDW-1:0] join_id,
    input  logic           issue_en,
    input  logic [IDW-1:0] issue_id,
    input  logic           exec_en,
    input  logic [IDW-1:0] exec_id,
    output logic [NG-1:0]  slot_valid,
    output logic [NG-1:0]  slot_started,
    output logic [NG-1:0]  slot_ready,
    output logic           free_en,
    output logic [IDW-1:0] free_id
);
    logic [NG-1:0] valid_q;
    logic [NG-1:0] started_q;
    logic [IW-1:0] ninst_q [NG];
    logic [IW-1:0] nexec_q [NG];
    logic [PW-1:0] npred_q [NG];
    logic [NG-1:0] succ_q  [NG];

    logic [NG-1:0] freed_row;
    logic [NG-1:0] free_col;
    logic [NG-1:0] new_col;

    assign free_en  = exec_en && valid_q[exec_id] &&
                      ((nexec_q[exec_id] + IW'(1)) == ninst_q[exec_id]);
    assign free_id  = exec_id;
    assign freed_row = free_en ? succ_q[exec_id] : '0;

    always_comb begin
        free_col = '0;
        new_col  = '0;
        if (free_en)  free_col[exec_id]  = 1'b1;
        if (alloc_en) new_col[alloc_id]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= '0;
            started_q <= '0;
            for (int i = 0; i < NG; i++) begin
                ninst_q[i] <= '0;
                nexec_q[i] <= '0;
                npred_q[i] <= '0;
                succ_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NG; i++) begin
                if (alloc_en && alloc_id == IDW'(i)) begin
                    valid_q[i]   <= 1'b1;
                    started_q[i] <= 1'b0;
                    ninst_q[i]   <= IW'(1);
                    nexec_q[i]   <= '0;
                    npred_q[i]   <= PW'($countones(alloc_pred));
                    succ_q[i]    <= '0;
                end else if (free_en && free_id == IDW'(i)) begin
                    valid_q[i]   <= 1'b0;
                    started_q[i] <= 1'b0;
                    succ_q[i]    <= '0;
                end else if (valid_q[i]) begin
                    if (join_en && join_id == IDW'(i))
                        ninst_q[i] <= ninst_q[i] + IW'(1);
                    if (exec_en && exec_id == IDW'(i))
                        nexec_q[i] <= nexec_q[i] + IW'(1);
                    if ((issue_en && issue_id == IDW'(i)) || (exec_en && exec_id == IDW'(i)))
                        started_q[i] <= 1'b1;
                    if (freed_row[i] && npred_q[i] != '0)
                        npred_q[i] <= npred_q[i] - PW'(1);
                    succ_q[i] <= (succ_q[i] | (alloc_pred[i] ? new_col : '0)) & ~free_col;
                end
            end
        end
    end

    assign slot_valid   = valid_q;
    assign slot_started = started_q;

    for (genvar g = 0; g < NG; g++) begin : g_ready
        assign slot_ready[g] = valid_q[g] && (npred_q[g] == '0);
    end

    AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !valid_q[alloc_id]);  // R2
    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        free_en |=> !valid_q[$past(free_id)]);  // R10
    AST_JOIN_LIVE: assert property (@(posedge clk) disable iff (rst)
        join_en |-> (valid_q[join_id] && !started_q[join_id]));  // R7
    AST_NEW_GROUP_NOT_STARTED: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> !started_q[$past(alloc_id)]);  // R7

endmodule

// File: rtl/mot_dispatch_ctrl.sv
module mot_dispatch_ctrl
    import mot_pkg::*;
#(
    parameter int unsigned NG = 8,
    localparam int unsigned IDW = $clog2(NG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  mem_op_t        op,
    input  logic           no_alias,
    input  logic           lq_full,
    input  logic           sq_full,
    input  logic [NG-1:0]  slot_valid,
    input  logic [NG-1:0]  slot_started,
    input  logic           free_en,
    input  logic [IDW-1:0] free_id,
    output disp_status_e   status,
    output logic           accept,
    output logic [IDW-1:0] grp_id,
    output logic           alloc_en,
    output logic [IDW-1:0] alloc_id,
    output logic [NG-1:0]  alloc_pred,
    output logic           join_en,
    output logic [IDW-1:0] join_id
);
    logic [IDW-1:0] ptr_ld_q, ptr_st_q, ptr_lb_q, ptr_sb_q, next_q;
    logic           st_newer_q;

    logic [IDW-1:0] p_ld, p_st, p_lb, p_sb, dom;
    logic           st_newer, new_ld_grp, need_slot;

    function automatic logic [NG-1:0] id_bit(input logic [IDW-1:0] id);
        logic [NG-1:0] v;
        v = '0;
        if (id != '0) v[id] = 1'b1;
        return v;
    endfunction

    // Pointers as seen after a release in this cycle
    assign p_ld     = (free_en && ptr_ld_q == free_id) ? '0 : ptr_ld_q;
    assign p_st     = (free_en && ptr_st_q == free_id) ? '0 : ptr_st_q;
    assign p_lb     = (free_en && ptr_lb_q == free_id) ? '0 : ptr_lb_q;
    assign p_sb     = (free_en && ptr_sb_q == free_id) ? '0 : ptr_sb_q;
    assign st_newer = st_newer_q && (p_st != '0);
    assign dom      = (p_ld != '0) ? p_ld : p_lb;

    assign new_ld_grp = op.is_bar || (dom == '0) || (dom == p_lb) ||
                        st_newer || slot_started[dom];
    assign need_slot  = op.is_st || (op.is_ld && new_ld_grp);

    always_comb begin
        if (op.is_ld && lq_full)               status = DS_LQ_FULL;
        else if (op.is_st && sq_full)          status = DS_SQ_FULL;
        else if (need_slot && slot_valid[next_q]) status = DS_NO_SLOT;
        else                                   status = DS_AVAIL;
    end

    assign accept   = op_valid && (op.is_ld || op.is_st) && (status == DS_AVAIL);
    assign alloc_en = accept && need_slot;
    assign alloc_id = next_q;
    assign join_en  = accept && !need_slot;
    assign join_id  = dom;
    assign grp_id   = !accept ? '0 : (need_slot ? next_q : dom);

    always_comb begin
        alloc_pred = '0;
        if (op.is_st) begin
            if (!no_alias) alloc_pred |= id_bit(dom);
            alloc_pred |= id_bit(p_sb);
            if (!no_alias && p_st != p_sb) alloc_pred |= id_bit(p_st);
        end else begin
            if (!no_alias) alloc_pred |= id_bit(p_st);
            if (op.is_bar) alloc_pred |= id_bit(dom);
            else           alloc_pred |= id_bit(p_lb);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_ld_q   <= '0;
            ptr_st_q   <= '0;
            ptr_lb_q   <= '0;
            ptr_sb_q   <= '0;
            st_newer_q <= 1'b0;
            next_q     <= IDW'(1);
        end else begin
            ptr_ld_q   <= p_ld;
            ptr_st_q   <= p_st;
            ptr_lb_q   <= p_lb;
            ptr_sb_q   <= p_sb;
            st_newer_q <= st_newer;
            if (alloc_en) begin
                next_q <= (next_q == IDW'(NG - 1)) ? IDW'(1) : next_q + IDW'(1);
                if (op.is_st) begin
                    ptr_st_q   <= next_q;
                    st_newer_q <= 1'b1;
                    if (op.is_bar) ptr_sb_q <= next_q;
                    if (op.is_ld) begin
                        ptr_ld_q <= next_q;
                        if (op.is_bar) ptr_lb_q <= next_q;
                    end
                end else begin
                    ptr_ld_q   <= next_q;
                    st_newer_q <= 1'b0;
                    if (op.is_bar) ptr_lb_q <= next_q;
                end
            end
        end
    end

    AST_GID_NONZERO: assert property (@(posedge clk) disable iff (rst)
        accept |-> grp_id != '0);  // R2
    AST_STORE_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (accept && op.is_st) |=> ptr_st_q == $past(grp_id));  // R5
    AST_FREED_PTR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        free_en |=> (ptr_ld_q != $past(free_id)) && (ptr_st_q != $past(free_id)) &&
                    (ptr_lb_q != $past(free_id)) && (ptr_sb_q != $past(free_id)));  // R10
    AST_PRED_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !alloc_pred[alloc_id] && !alloc_pred[0]);  // R9

endmodule

// File: rtl/mem_order_tracker.sv
module mem_order_tracker
    import mot_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned LQ_DEPTH   = 4,
    parameter int unsigned SQ_DEPTH   = 4,
    localparam int unsigned IDW = $clog2(NUM_GROUPS),
    localparam int unsigned LQW = width_for(LQ_DEPTH),
    localparam int unsigned SQW = width_for(SQ_DEPTH),
    localparam int unsigned IW  = $clog2(LQ_DEPTH + SQ_DEPTH) + 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  no_alias,
    input  logic                  disp_valid,
    input  logic                  disp_load,
    input  logic                  disp_store,
    input  logic                  disp_barrier,
    output logic [1:0]            disp_status,
    output logic                  disp_accept,
    output logic [IDW-1:0]        disp_gid,
    input  logic                  issue_valid,
    input  logic [IDW-1:0]        issue_gid,
    input  logic                  exec_valid,
    input  logic [IDW-1:0]        exec_gid,
    input  logic                  retire_valid,
    input  logic                  retire_load,
    input  logic                  retire_store,
    output logic [NUM_GROUPS-1:0] grp_ready,
    output logic [LQW-1:0]        lq_used,
    output logic [SQW-1:0]        sq_used
);
    mem_op_t         op;
    disp_status_e    status;
    logic            lq_full, sq_full;
    logic [NUM_GROUPS-1:0] slot_valid, slot_started;
    logic            free_en, alloc_en, join_en;
    logic [IDW-1:0]  free_id, alloc_id, join_id;
    logic [NUM_GROUPS-1:0] alloc_pred;

    assign op = '{is_ld: disp_load, is_st: disp_store, is_bar: disp_barrier};
    assign disp_status = status;

    mot_queue_count #(.DEPTH(LQ_DEPTH)) u_lq (
        .clk(clk), .rst(rst),
        .inc(disp_accept && disp_load),
        .dec(retire_valid && retire_load),
        .count(lq_used), .full(lq_full));

    mot_queue_count #(.DEPTH(SQ_DEPTH)) u_sq (
        .clk(clk), .rst(rst),
        .inc(disp_accept && disp_store),
        .dec(retire_valid && retire_store),
        .count(sq_used), .full(sq_full));

    mot_dispatch_ctrl #(.NG(NUM_GROUPS)) u_ctrl (
        .clk(clk), .rst(rst),
        .op_valid(disp_valid), .op(op), .no_alias(no_alias),
        .lq_full(lq_full), .sq_full(sq_full),
        .slot_valid(slot_valid), .slot_started(slot_started),
        .free_en(free_en), .free_id(free_id),
        .status(status), .accept(disp_accept), .grp_id(disp_gid),
        .alloc_en(alloc_en), .alloc_id(alloc_id), .alloc_pred(alloc_pred),
        .join_en(join_en), .join_id(join_id));

    mot_group_table #(.NG(NUM_GROUPS), .IW(IW)) u_tab (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_en), .alloc_id(alloc_id), .alloc_pred(alloc_pred),
        .join_en(join_en), .join_id(join_id),
        .issue_en(issue_valid), .issue_id(issue_gid),
        .exec_en(exec_valid), .exec_id(exec_gid),
        .slot_valid(slot_valid), .slot_started(slot_started),
        .slot_ready(grp_ready),
        .free_en(free_en), .free_id(free_id));

    AST_READY_IMPLIES_LIVE: assert property (@(posedge clk) disable iff (rst)
        (grp_ready & ~slot_valid) == '0);  // R9
    AST_NOTHING_WITHOUT_KIND: assert property (@(posedge clk) disable iff (rst)
        (!disp_load && !disp_store) |-> !disp_accept);  // R12

endmodule

// File: tb/mem_order_tracker_tb.sv
module mem_order_tracker_tb_top;
    localparam int NG  = 8;
    localparam int LQD = 4;
    localparam int SQD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic na = 0, d_v = 0, d_ld = 0, d_st = 0, d_bar = 0;
    logic is_v = 0, ex_v = 0, rt_v = 0, rt_ld = 0, rt_st = 0;
    logic [2:0] is_id = 0, ex_id = 0;
    logic [1:0] disp_status;
    logic       disp_accept;
    logic [2:0] disp_gid;
    logic [NG-1:0] grp_ready;
    logic [2:0] lq_used, sq_used;

    mem_order_tracker dut_i (
        .clk(clk), .rst(rst), .no_alias(na),
        .disp_valid(d_v), .disp_load(d_ld), .disp_store(d_st), .disp_barrier(d_bar),
        .disp_status(disp_status), .disp_accept(disp_accept), .disp_gid(disp_gid),
        .issue_valid(is_v), .issue_gid(is_id),
        .exec_valid(ex_v), .exec_gid(ex_id),
        .retire_valid(rt_v), .retire_load(rt_ld), .retire_store(rt_st),
        .grp_ready(grp_ready), .lq_used(lq_used), .sq_used(sq_used));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int last_gid, last_status, last_acc;

    // Behavioural model: groups ordered by creation stamp, explicit pending sets
    bit     mv [NG];
    bit     mstart [NG];
    int     mninst [NG], mnexec [NG];
    longint mseq [NG];
    bit     mpend [NG][NG];
    int     mld, mst, mlb, msb, mnext, mlq, msq;
    longint seqc;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint age(input int id);
        return (id == 0) ? 0 : mseq[id];
    endfunction

    function automatic int exp_ready();
        int v = 0;
        for (int i = 1; i < NG; i++) begin
            bit ok = mv[i];
            for (int j = 0; j < NG; j++) if (mpend[i][j]) ok = 0;
            if (ok) v |= (1 << i);
        end
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NG; i++) begin
            mv[i] = 0; mstart[i] = 0; mninst[i] = 0; mnexec[i] = 0; mseq[i] = 0;
            for (int j = 0; j < NG; j++) mpend[i][j] = 0;
        end
        mld = 0; mst = 0; mlb = 0; msb = 0; mnext = 1; mlq = 0; msq = 0; seqc = 0;
    endtask

    task automatic step();
        int fid, pld, pst, plb, psb, dom, st, acc, gid;
        bit newg, need;
        bit pm [NG];
        #1;
        fid = 0;
        if (ex_v && mv[ex_id] && mnexec[ex_id] + 1 == mninst[ex_id]) fid = ex_id;
        pld = (fid != 0 && mld == fid) ? 0 : mld;
        pst = (fid != 0 && mst == fid) ? 0 : mst;
        plb = (fid != 0 && mlb == fid) ? 0 : mlb;
        psb = (fid != 0 && msb == fid) ? 0 : msb;
        dom = (age(pld) >= age(plb)) ? pld : plb;
        newg = d_bar || dom == 0 || dom == plb ||
               (pst != 0 && age(dom) <= age(pst)) || mstart[dom];
        need = d_st || (d_ld && newg);
        st = 0;
        if (d_ld && mlq == LQD)       st = 1;
        else if (d_st && msq == SQD)  st = 2;
        else if (need && mv[mnext])   st = 3;
        acc = (d_v && (d_ld || d_st) && st == 0) ? 1 : 0;
        gid = (acc == 0) ? 0 : (need ? mnext : dom);
        check("R3 status", int'(disp_status), st);
        check("R12 accept", int'(disp_accept), acc);
        check("R2 group id", int'(disp_gid), gid);
        check("R9 ready vector", int'(grp_ready), exp_ready());
        check("R4 load count", int'(lq_used), mlq);
        check("R4 store count", int'(sq_used), msq);
        last_gid = int'(disp_gid); last_status = int'(disp_status); last_acc = int'(disp_accept);
        for (int j = 0; j < NG; j++) pm[j] = 0;
        if (d_st) begin
            if (!na && dom != 0) pm[dom] = 1;
            if (psb != 0) pm[psb] = 1;
            if (!na && pst != 0 && pst != psb) pm[pst] = 1;
        end else begin
            if (!na && pst != 0) pm[pst] = 1;
            if (d_bar) begin if (dom != 0) pm[dom] = 1; end
            else if (plb != 0) pm[plb] = 1;
        end
        @(posedge clk);
        if (ex_v && mv[ex_id]) begin
            if (fid != 0) begin
                mv[fid] = 0;
                for (int i = 0; i < NG; i++) mpend[i][fid] = 0;
            end else begin
                mnexec[ex_id]++; mstart[ex_id] = 1;
            end
        end
        if (is_v && mv[is_id]) mstart[is_id] = 1;
        mld = pld; mst = pst; mlb = plb; msb = psb;
        if (acc != 0) begin
            if (need) begin
                mv[mnext] = 1; mstart[mnext] = 0; mninst[mnext] = 1; mnexec[mnext] = 0;
                seqc++; mseq[mnext] = seqc;
                for (int j = 0; j < NG; j++) mpend[mnext][j] = pm[j];
                if (d_st) begin
                    mst = mnext; if (d_bar) msb = mnext;
                    if (d_ld) begin mld = mnext; if (d_bar) mlb = mnext; end
                end else begin
                    mld = mnext; if (d_bar) mlb = mnext;
                end
                mnext = (mnext == NG - 1) ? 1 : mnext + 1;
            end else begin
                mninst[dom]++;
            end
        end
        mlq = mlq + ((acc != 0 && d_ld) ? 1 : 0) - ((rt_v && rt_ld && mlq > 0) ? 1 : 0);
        msq = msq + ((acc != 0 && d_st) ? 1 : 0) - ((rt_v && rt_st && msq > 0) ? 1 : 0);
        @(negedge clk);
    endtask

    task automatic clear_in();
        d_v = 0; d_ld = 0; d_st = 0; d_bar = 0;
        is_v = 0; is_id = 0; ex_v = 0; ex_id = 0; rt_v = 0; rt_ld = 0; rt_st = 0;
    endtask

    task automatic do_reset();
        clear_in();
        rst = 1;
        model_reset();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic disp(input bit l, input bit s, input bit b);
        clear_in(); d_v = 1; d_ld = l; d_st = s; d_bar = b; step(); clear_in();
    endtask

    task automatic exec_one(input int id);
        clear_in(); ex_v = 1; ex_id = 3'(id); step(); clear_in();
    endtask

    task automatic issue_one(input int id);
        clear_in(); is_v = 1; is_id = 3'(id); step(); clear_in();
    endtask

    task automatic idle();
        clear_in(); step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 ready after reset", int'(grp_ready), 0);
        check("R1 load count after reset", int'(lq_used), 0);
        check("R1 store count after reset", int'(sq_used), 0);
        // R12: stray events and empty dispatch change nothing
        exec_one(6);
        issue_one(3);
        disp(0, 0, 0);
        check("R12 empty dispatch not accepted", last_acc, 0);
        disp(0, 1, 0);
        check("R1 first id", last_gid, 1);
        // load after store opens a group and waits
        disp(1, 0, 0);
        check("R8 load group id", last_gid, 2);
        idle();
        check("R8 load waits for store", int'(grp_ready[2]), 0);
        disp(1, 0, 0);
        check("R7 load joins group", last_gid, 2);
        issue_one(2);
        disp(1, 0, 0);
        check("R7 started group not joined", last_gid, 3);
        exec_one(1);
        idle();
        check("R9 ready after predecessor released", int'(grp_ready[2]), 1);
        disp(0, 1, 0);
        check("R5 store group id", last_gid, 4);
        idle();
        check("R5 store waits for load", int'(grp_ready[4]), 0);
        exec_one(2); exec_one(2); exec_one(3); exec_one(4);
        idle();
        check("R10 all released", int'(grp_ready), 0);
        disp(1, 0, 0);
        check("R10 no join after release", last_gid, 5);
        idle();
        check("R10 fresh load ready", int'(grp_ready[5]), 1);

        // R6 no-alias mode
        do_reset();
        na = 1;
        disp(0, 1, 0);
        disp(1, 0, 0);
        idle();
        check("R6 load skips store edge", int'(grp_ready[2]), 1);
        disp(0, 1, 0);
        idle();
        check("R6 store skips load and store edges", int'(grp_ready[3]), 1);
        disp(0, 1, 1);
        disp(0, 1, 0);
        idle();
        check("R6 store barrier edge kept", int'(grp_ready[5]), 0);
        na = 0;

        // load barriers
        do_reset();
        disp(1, 0, 0);
        disp(1, 0, 1);
        idle();
        check("R8 barrier load waits", int'(grp_ready[2]), 0);
        disp(1, 0, 0);
        check("R7 load after barrier opens group", last_gid, 3);
        idle();
        check("R8 load waits for barrier", int'(grp_ready[3]), 0);

        // queue status priority
        do_reset();
        repeat (4) disp(1, 0, 0);
        disp(1, 0, 0);
        check("R3 load queue full", last_status, 1);
        disp(1, 1, 0);
        check("R3 load test first", last_status, 1);
        repeat (4) disp(0, 1, 0);
        disp(0, 1, 0);
        check("R3 store queue full", last_status, 2);
        repeat (6) begin clear_in(); rt_v = 1; rt_ld = 1; rt_st = 1; step(); end
        clear_in();
        check("R4 retire saturates", int'(lq_used) + int'(sq_used), 0);

        // slot exhaustion, wrap, same-cycle release
        do_reset();
        repeat (7) begin clear_in(); d_v = 1; d_st = 1; rt_v = 1; rt_st = 1; step(); end
        disp(0, 1, 0);
        check("R2 no free slot", last_status, 3);
        clear_in(); d_v = 1; d_st = 1; ex_v = 1; ex_id = 1; step();
        check("R11 slot judged before release", last_status, 3);
        clear_in(); rt_v = 1; rt_st = 1; step();
        disp(0, 1, 0);
        check("R2 id wraps to 1", last_gid, 1);

        do_reset();
        disp(1, 0, 0);
        clear_in(); d_v = 1; d_ld = 1; ex_v = 1; ex_id = 1; step(); clear_in();
        check("R11 released group not joined", last_gid, 2);

        // random phase
        for (int seg = 0; seg < 6; seg++) begin
            do_reset();
            na = seg[0];
            for (int c = 0; c < 700; c++) begin
                clear_in();
                d_v   = ($urandom_range(0, 9) < 6);
                d_ld  = $urandom_range(0, 1);
                d_st  = ($urandom_range(0, 2) == 0);
                d_bar = ($urandom_range(0, 6) == 0);
                is_v  = ($urandom_range(0, 9) < 3);
                is_id = 3'($urandom_range(1, NG - 1));
                ex_v  = ($urandom_range(0, 9) < 5);
                ex_id = 3'($urandom_range(0, NG - 1));
                rt_v  = ($urandom_range(0, 9) < 3);
                rt_ld = $urandom_range(0, 1);
                rt_st = $urandom_range(0, 1);
                step();
            end
        end
        clear_in();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule